// File: doc/BRIEF.md
# Wide-Output LFSR Random Word Generator

The block generates pseudo-random 32-bit words from a 33-bit shift register with exclusive-OR feedback. A request on `next_i` advances the register by 32 single-bit steps within one clock. The fresh word appears on `word_o` one clock later, and `valid_o` pulses high for that one cycle. All 32 steps are unrolled into a single combinational network, so a new word can be requested on every cycle.

Software or a neighbouring block seeds the generator with a 33-bit value through `seed_load_i`. A 33-bit register with two feedback taps gives a sequence that does not repeat within 2^32-1 steps. A 32-bit register with one pair of taps cannot reach that length. A seed of all zeros would stop the generator, so the block replaces such a seed with a fixed nonzero constant.

Top module: `rng_wide`

## Requirements
- R1: After reset, `valid_o` is 0, `word_o` is 0, and the state holds RESET_SEED, whose default is 33'h0_0000_0001.
- R2: A cycle in which `next_i` is 1 and `seed_load_i` is 0 makes `valid_o` 1 in the following cycle only. If no further request follows, `valid_o` returns to 0.
- R3: The state bits are numbered 1 to 33, and state bit k is `seed_i[k-1]`. One step computes a new bit as bit 33 XOR bit 20, shifts the register left by one, and puts the new bit in bit 1. A request applies 32 steps, and `word_o` becomes state bits 32 down to 1 after those steps.
- R4: Requests on back-to-back cycles give a word on every cycle, and each word continues the sequence from the state the previous request left.
- R5: `seed_load_i` replaces the state with `seed_i`. `valid_o` stays 0 and `word_o` is unchanged in the cycle after the load, and the next request steps from the loaded seed.
- R6: Loading an all-zero seed sets the state to ZERO_SUB instead, whose default is 33'h1_DEAD_BEEF.
- R7: When `seed_load_i` and `next_i` are both 1 in the same cycle, only the load takes effect. No word is produced and `word_o` keeps its value.
- R8: `word_o` keeps its value in every cycle that does not follow a request.
- R9: The state never becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_load_i | input | 1 | Load `seed_i` into the state |
| seed_i | input | 33 | Seed value; bit k-1 sets state bit k |
| next_i | input | 1 | Request a new 32-bit word |
| word_o | output | 32 | Most recent random word |
| valid_o | output | 1 | One-cycle pulse when `word_o` is new |

## Verification
A seed load and a word request can arrive in the same cycle, and they collide on the state register. The bench provokes this by raising `seed_load_i` and `next_i` on the same clock edge. It judges the result in three ways. In the following cycle it requires `valid_o` to be low and `word_o` to be unchanged. It then issues a plain request and requires the word computed from the new seed, not from the old state stepped forward. A reference stepper in the bench applies the bit 33 / bit 20 rule one bit at a time and supplies every expected word.

// File: rtl/rng_wide_pkg.sv
package rng_wide_pkg;
  localparam int unsigned DEF_STATE_W = 33;
  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned DEF_STEPS   = 32;
  localparam int unsigned DEF_TAP_HI  = 33;
  localparam int unsigned DEF_TAP_LO  = 20;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } rng_act_e;
endpackage

// File: rtl/rng_step.sv
// One LFSR step: shift left, feedback bit enters at bit 0.
module rng_step #(
  parameter int unsigned W      = 33,
  parameter int unsigned TAP_HI = 33,
  parameter int unsigned TAP_LO = 20
) (
  input  logic [W-1:0] s_i,
  output logic [W-1:0] s_o
);
  localparam int unsigned HI_IDX = TAP_HI - 1;
  localparam int unsigned LO_IDX = TAP_LO - 1;

  assign s_o = {s_i[W-2:0], s_i[HI_IDX] ^ s_i[LO_IDX]};
endmodule

// File: rtl/rng_unroll.sv
module rng_unroll #(
  parameter int unsigned W      = 33,
  parameter int unsigned STEPS  = 32,
  parameter int unsigned TAP_HI = 33,
  parameter int unsigned TAP_LO = 20
) (
  input  logic [W-1:0] s_i,
  output logic [W-1:0] s_o
);
  logic [W-1:0] chain [STEPS+1];

  assign chain[0] = s_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    rng_step #(.W(W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_step (
      .s_i(chain[g]),
      .s_o(chain[g+1])
    );
  end

  assign s_o = chain[STEPS];
endmodule

// File: rtl/rng_seed_guard.sv
// An all-zero seed would lock the LFSR; substitute a nonzero constant.
module rng_seed_guard #(
  parameter int unsigned   W        = 33,
  parameter logic [W-1:0]  ZERO_SUB = 33'h1_DEAD_BEEF
) (
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] seed_o
);
  assign seed_o = (seed_i == '0) ? ZERO_SUB : seed_i;
endmodule

// File: rtl/rng_wide.sv
module rng_wide
  import rng_wide_pkg::*;
#(
  parameter int unsigned        STATE_W    = DEF_STATE_W,
  parameter int unsigned        WORD_W     = DEF_WORD_W,
  parameter int unsigned        STEPS      = DEF_STEPS,
  parameter int unsigned        TAP_HI     = DEF_TAP_HI,
  parameter int unsigned        TAP_LO     = DEF_TAP_LO,
  parameter logic [STATE_W-1:0] RESET_SEED = 33'h0_0000_0001,
  parameter logic [STATE_W-1:0] ZERO_SUB   = 33'h1_DEAD_BEEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               seed_load_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic               next_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               valid_o
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_adv;
  logic [STATE_W-1:0] seed_safe;
  rng_act_e           act;

  rng_unroll #(
    .W(STATE_W), .STEPS(STEPS), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)
  ) u_unroll (
    .s_i(state_q),
    .s_o(state_adv)
  );

  rng_seed_guard #(.W(STATE_W), .ZERO_SUB(ZERO_SUB)) u_guard (
    .seed_i(seed_i),
    .seed_o(seed_safe)
  );

  // Load wins over a simultaneous step request.
  always_comb begin
    if (seed_load_i)  act = ACT_LOAD;
    else if (next_i)  act = ACT_STEP;
    else              act = ACT_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RESET_SEED;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (act)
        ACT_LOAD: state_q <= seed_safe;
        ACT_STEP: begin
          state_q <= state_adv;
          word_o  <= state_adv[WORD_W-1:0];
          valid_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rng_wide_chk.sv
module rng_wide_chk #(
  parameter int unsigned STATE_W = 33,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned STEPS   = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               seed_load_i,
  input logic               next_i,
  input logic               valid_o,
  input logic [WORD_W-1:0]  word_o,
  input logic [STATE_W-1:0] state_q
);
  assert_req_gives_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_i && !seed_load_i) |=> valid_o);

  assert_valid_has_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(next_i && !seed_load_i));

  // After STEPS shifts the old bit 0 sits at index STEPS.
  assert_shift_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (state_q[STEPS] == $past(state_q[0])));

  assert_load_priority_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> (!valid_o && $stable(word_o)));

  assert_word_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));

  assert_state_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

bind rng_wide rng_wide_chk #(
  .STATE_W(STATE_W), .WORD_W(WORD_W), .STEPS(STEPS)
) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .seed_load_i(seed_load_i),
  .next_i(next_i),
  .valid_o(valid_o),
  .word_o(word_o),
  .state_q(state_q)
);

// File: tb/rng_wide_test.sv
module rng_wide_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seed_load_i = 1'b0;
  logic [32:0] seed_i = '0;
  logic        next_i = 1'b0;
  logic [31:0] word_o;
  logic        valid_o;

  int total = 0;
  int bad   = 0;
  logic [32:0] model;

  localparam logic [32:0] RST_SEED = 33'h0_0000_0001;
  localparam logic [32:0] ZSUB     = 33'h1_DEAD_BEEF;

  always #10 clk_i = ~clk_i;

  rng_wide uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .seed_load_i(seed_load_i), .seed_i(seed_i),
    .next_i(next_i), .word_o(word_o), .valid_o(valid_o)
  );

  // Reference: bits numbered 1..33 map to index 0..32.
  function automatic logic [32:0] adv(input logic [32:0] s);
    logic [32:0] t = s;
    for (int k = 0; k < 32; k++) begin
      logic nb = t[32] ^ t[19];
      t = {t[31:0], nb};
    end
    return t;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic request_word(input string req);
    logic [31:0] prev = word_o;
    @(negedge clk_i) next_i = 1'b1;
    @(negedge clk_i) next_i = 1'b0;
    model = adv(model);
    chk(req, {63'd0, valid_o}, 64'd1);
    chk(req, {32'd0, word_o}, {32'd0, model[31:0]});
    @(negedge clk_i);
    chk("R2", {63'd0, valid_o}, 64'd0);
    chk("R8", {32'd0, word_o}, {32'd0, model[31:0]});
    if (prev == model[31:0]) $display("note: repeated word");
  endtask

  task automatic load_seed(input logic [32:0] s, input string req);
    logic [31:0] prev = word_o;
    @(negedge clk_i) begin seed_load_i = 1'b1; seed_i = s; end
    @(negedge clk_i) seed_load_i = 1'b0;
    model = (s == '0) ? ZSUB : s;
    chk(req, {63'd0, valid_o}, 64'd0);
    chk(req, {32'd0, word_o}, {32'd0, prev});
  endtask

  task automatic t_reset();
    chk("R1", {63'd0, valid_o}, 64'd0);
    chk("R1", {32'd0, word_o}, 64'd0);
    model = RST_SEED;
    request_word("R1");
  endtask

  task automatic t_seeded();
    load_seed(33'h1_2345_6789, "R5");
    request_word("R5");
    request_word("R3");
    load_seed(33'h1_0000_0000, "R5");
    request_word("R3");
  endtask

  task automatic t_back_to_back();
    load_seed(33'h0_CAFE_F00D, "R5");
    @(negedge clk_i) next_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      model = adv(model);
      chk("R4", {63'd0, valid_o}, 64'd1);
      chk("R4", {32'd0, word_o}, {32'd0, model[31:0]});
    end
    next_i = 1'b0;
    @(negedge clk_i);
    chk("R2", {63'd0, valid_o}, 64'd0);
  endtask

  task automatic t_zero_seed();
    load_seed(33'h0, "R6");
    request_word("R6");
  endtask

  task automatic t_collision();
    logic [31:0] prev = word_o;
    @(negedge clk_i) begin seed_load_i = 1'b1; next_i = 1'b1; seed_i = 33'h1_0F0F_1234; end
    @(negedge clk_i) begin seed_load_i = 1'b0; next_i = 1'b0; end
    model = 33'h1_0F0F_1234;
    chk("R7", {63'd0, valid_o}, 64'd0);
    chk("R7", {32'd0, word_o}, {32'd0, prev});
    request_word("R7");
  endtask

  task automatic t_idle_hold();
    repeat (5) @(negedge clk_i);
    chk("R8", {32'd0, word_o}, {32'd0, model[31:0]});
    chk("R8", {63'd0, valid_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_seeded();
    t_back_to_back();
    t_zero_seed();
    t_collision();
    t_idle_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule